// File: doc/BRIEF.md
# SPI Controller Interrupt Status and Clear Registers

This block collects the interrupt sources of a serial peripheral controller and turns them into one interrupt line. Two of the sources are FIFO fill-level conditions: the transmit FIFO has drained below its threshold, and the receive FIFO has filled to or above its threshold. These appear live, following their inputs in the same cycle. The other three are error events: transmit overflow, receive underflow and receive overflow. Each arrives as a one-cycle pulse and is latched, and it stays latched until software clears it.

Software reaches the block through a simple register port. The port has a write strobe, a 2-bit word address, write data, and read data that is combinational on the address. The port exposes the raw status, an enable mask, the masked status and a write-one-to-clear register. The clear register has its own 4-bit layout. Its lowest bit clears every latched error at once, and each of the other three bits clears one error.

Top module: `irq_status_regs`

## Requirements
- R1: After reset the mask is 0, all latched errors are 0 and `irq_o` is 0.
- R2: Reading address 0 returns the raw status: bit 0 = `tx_low_i` (live), bit 1 = latched transmit overflow, bit 2 = latched receive underflow, bit 3 = latched receive overflow, bit 4 = `rx_high_i` (live). The live bits follow their inputs in the same cycle.
- R3: A one-cycle pulse on `tx_ovf_p`, `rx_udf_p` or `rx_ovf_p` sets its raw bit from the next cycle onward. The bit stays set until it is cleared.
- R4: A write to address 3 clears single errors one cycle later: wdata bit 1 clears receive underflow, bit 2 clears receive overflow and bit 3 clears transmit overflow. A latched bit whose clear bit is 0 is not affected.
- R5: A write to address 3 with wdata bit 0 set clears all three latched errors.
- R6: When a clear and a new event for the same error fall in the same cycle, the bit stays set.
- R7: A write to address 1 loads the 5-bit mask, which reads back at address 1. Address 2 reads raw status AND mask.
- R8: `irq_o` is 1 exactly when some bit of raw status AND mask is 1.
- R9: Writes to addresses 0 and 2 change nothing. Reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_low_i | input | 1 | Transmit FIFO level below threshold (live) |
| rx_high_i | input | 1 | Receive FIFO level at or above threshold (live) |
| tx_ovf_p | input | 1 | Transmit overflow event pulse |
| rx_udf_p | input | 1 | Receive underflow event pulse |
| rx_ovf_p | input | 1 | Receive overflow event pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address: 0 raw, 1 mask, 2 masked, 3 clear |
| reg_wdata | input | 5 | Register write data |
| reg_rdata | output | 5 | Register read data, combinational on `reg_addr` |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the latching rules on every cycle for each error flag. An event sets its flag, a set flag holds unless cleared, a clear without an event empties the flag, and nothing sets a flag without an event. The assertions also check that the mask loads only on its own write, that an all-zero mask keeps the interrupt low, and that writes to the read-only addresses leave the flags alone. The bench scenarios show what no single-cycle property captures. These are the mapping from clear bits to flags, including clear-all, the placement of each source in the status word, and the agreement of the masked status and the interrupt line with a reference model over long random mixes of events, writes and level changes.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int STAT_W = 5;
  localparam int CLR_W  = 4;
  localparam int ERR_N  = 3;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_RAW  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_MSKD = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CLR  = 2'd3;

  // error flag order inside the bank: 0 tx overflow, 1 rx underflow, 2 rx overflow
  // clear word: bit0 all, bit1 rx underflow, bit2 rx overflow, bit3 tx overflow
  function automatic logic [ERR_N-1:0] clr_to_err(input logic [CLR_W-1:0] w);
    logic [ERR_N-1:0] r;
    r[0] = w[0] | w[3];
    r[1] = w[0] | w[1];
    r[2] = w[0] | w[2];
    return r;
  endfunction

  function automatic logic [STAT_W-1:0] pack_raw(input logic tx_low,
                                                 input logic [ERR_N-1:0] err,
                                                 input logic rx_high);
    return {rx_high, err, tx_low};
  endfunction
endpackage

// File: rtl/irq_sticky_flag.sv
module irq_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R3: an event latches the flag (and R6: even with a clear in the same cycle)
  a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  a_r6_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> q_o);
  a_r3_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_o && !set_i) |=> !q_o);
  a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int N = irq_pkg::ERR_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    irq_sticky_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(ev_i[i]),
      .clr_i(clr_i[i]),
      .q_o  (flag_o[i])
    );
  end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [STAT_W-1:0] raw_i,
  input  logic [STAT_W-1:0] mask_i,
  input  logic [STAT_W-1:0] mskd_i,
  output logic [STAT_W-1:0] rdata_o
);
  always_comb begin
    unique case (addr_i)
      ADDR_RAW:  rdata_o = raw_i;
      ADDR_MASK: rdata_o = mask_i;
      ADDR_MSKD: rdata_o = mskd_i;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_low_i,
  input  logic              rx_high_i,
  input  logic              tx_ovf_p,
  input  logic              rx_udf_p,
  input  logic              rx_ovf_p,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  output logic              irq_o
);
  logic [STAT_W-1:0] mask_q;
  logic [ERR_N-1:0]  err_ev;
  logic [ERR_N-1:0]  clr_vec;
  logic [ERR_N-1:0]  err_flag;
  logic [STAT_W-1:0] raw_stat;
  logic [STAT_W-1:0] mskd_stat;
  logic              mask_wr;
  logic              clr_wr;

  assign err_ev  = {rx_ovf_p, rx_udf_p, tx_ovf_p};
  assign mask_wr = reg_we && (reg_addr == ADDR_MASK);
  assign clr_wr  = reg_we && (reg_addr == ADDR_CLR);
  assign clr_vec = clr_wr ? clr_to_err(reg_wdata[CLR_W-1:0]) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= reg_wdata;
  end

  irq_sticky_bank #(.N(ERR_N)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .ev_i  (err_ev),
    .clr_i (clr_vec),
    .flag_o(err_flag)
  );

  assign raw_stat  = pack_raw(tx_low_i, err_flag, rx_high_i);
  assign mskd_stat = raw_stat & mask_q;
  assign irq_o     = |mskd_stat;

  irq_read_mux u_rd (
    .addr_i (reg_addr),
    .raw_i  (raw_stat),
    .mask_i (mask_q),
    .mskd_i (mskd_stat),
    .rdata_o(reg_rdata)
  );

  // R7: the mask loads on its own write and holds otherwise
  a_r7_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_MASK) |=> (mask_q == $past(reg_wdata)));
  a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == ADDR_MASK) |=> $stable(mask_q));
  // R8: nothing enabled, no interrupt
  a_r8_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);
  // R9: writes to read-only addresses leave the error flags untouched
  a_r9_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == ADDR_RAW || reg_addr == ADDR_MSKD) && err_ev == '0)
      |=> $stable(err_flag));
endmodule

// File: tb/sim_irq_status_regs.sv
`timescale 1ns/1ps
module sim_irq_status_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_low, rx_high, tx_ovf, rx_udf, rx_ovf, we;
  logic [1:0] addr;
  logic [4:0] wdata;
  logic [4:0] rdata;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [2:0] m_err;   // {rx ovf, rx udf, tx ovf}
  logic [4:0] m_mask;

  always #2 clk = ~clk;   // 250 MHz

  irq_status_regs u0 (
    .clk(clk), .rst_n(rst_n), .tx_low_i(tx_low), .rx_high_i(rx_high),
    .tx_ovf_p(tx_ovf), .rx_udf_p(rx_udf), .rx_ovf_p(rx_ovf),
    .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq_o(irq)
  );

  function automatic logic [4:0] exp_raw();
    logic [4:0] r;
    r[0] = tx_low; r[4] = rx_high;
    r[1] = m_err[0]; r[2] = m_err[1]; r[3] = m_err[2];
    return r;
  endfunction

  function automatic logic [4:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return exp_raw();
      2'd1: return m_mask;
      2'd2: return exp_raw() & m_mask;
      default: return 5'd0;
    endcase
  endfunction

  // which flags a clear word hits, written per flag
  function automatic logic [2:0] exp_clr(input logic [4:0] w);
    logic [2:0] c;
    c = 3'b000;
    if (w[0]) c = 3'b111;
    if (w[3]) c[0] = 1'b1;
    if (w[1]) c[1] = 1'b1;
    if (w[2]) c[2] = 1'b1;
    return c;
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle, check combinational outputs before the edge, then step the model
  task automatic cyc(input logic tl, input logic rh, input logic t_o, input logic r_u,
                     input logic r_o, input logic w, input logic [1:0] a,
                     input logic [4:0] wd);
    string tag;
    tx_low = tl; rx_high = rh; tx_ovf = t_o; rx_udf = r_u; rx_ovf = r_o;
    we = w; addr = a; wdata = wd;
    #1;
    case (a)
      2'd0: tag = "R2";
      2'd1: tag = "R7";
      2'd2: tag = "R7";
      default: tag = "R9";
    endcase
    check(tag, rdata, exp_read(a));
    check("R8", {4'b0, irq}, {4'b0, |(exp_raw() & m_mask)});
    @(posedge clk);
    if (w && a == 2'd3) m_err = m_err & ~exp_clr(wd);
    m_err = m_err | {r_o, r_u, t_o};
    if (w && a == 2'd1) m_mask = wd;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; tx_low = 0; rx_high = 0; tx_ovf = 0; rx_udf = 0; rx_ovf = 0;
    we = 0; addr = 0; wdata = 0;
    m_err = 3'b000; m_mask = 5'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of mask, flags and line
    addr = 2'd1; #1; check("R1", rdata, 5'b0);
    addr = 2'd0; #1; check("R1", rdata, 5'b0);
    check("R1", {4'b0, irq}, 5'b0);
    @(negedge clk);

    // R2: live bits follow inputs in the same cycle
    cyc(1, 0, 0, 0, 0, 0, 2'd0, 0);
    cyc(0, 1, 0, 0, 0, 0, 2'd0, 0);
    // R3: each pulse latches and holds
    cyc(0, 0, 1, 0, 0, 0, 2'd0, 0);
    cyc(0, 0, 0, 0, 0, 0, 2'd0, 0);
    cyc(0, 0, 0, 1, 0, 0, 2'd0, 0);
    cyc(0, 0, 0, 0, 1, 0, 2'd0, 0);
    cyc(0, 0, 0, 0, 0, 0, 2'd0, 0);
    check("R3", rdata, 5'b01110); // sampled after the step above (addr still 0)
    // R9: writes to raw and masked addresses do nothing; clear address reads 0
    cyc(0, 0, 0, 0, 0, 1, 2'd0, 5'b11111);
    cyc(0, 0, 0, 0, 0, 1, 2'd2, 5'b00000);
    cyc(0, 0, 0, 0, 0, 0, 2'd3, 0);
    // R4: single clears, one at a time
    cyc(0, 0, 0, 0, 0, 1, 2'd3, 5'b00010);
    cyc(0, 0, 0, 0, 0, 0, 2'd0, 0);
    cyc(0, 0, 0, 0, 0, 1, 2'd3, 5'b01000);
    cyc(0, 0, 0, 0, 0, 0, 2'd0, 0);
    cyc(0, 0, 0, 0, 0, 1, 2'd3, 5'b00100);
    cyc(0, 0, 0, 0, 0, 0, 2'd0, 0);
    check("R4", rdata, 5'b00000);
    // R5: clear-all
    cyc(0, 0, 1, 1, 1, 0, 2'd0, 0);
    cyc(0, 0, 0, 0, 0, 1, 2'd3, 5'b00001);
    cyc(0, 0, 0, 0, 0, 0, 2'd0, 0);
    check("R5", rdata, 5'b00000);
    // R6: event arriving with its own clear survives
    cyc(0, 0, 0, 0, 1, 1, 2'd3, 5'b00001);
    cyc(0, 0, 0, 0, 0, 0, 2'd0, 0);
    check("R6", rdata, 5'b01000);
    // R7 / R8: mask gates each source onto the line
    cyc(0, 0, 0, 0, 0, 1, 2'd1, 5'b00001);
    cyc(0, 0, 0, 0, 0, 0, 2'd2, 0);
    cyc(1, 0, 0, 0, 0, 0, 2'd2, 0);
    cyc(0, 0, 0, 0, 0, 1, 2'd1, 5'b01000);
    cyc(0, 0, 0, 0, 0, 0, 2'd2, 0);
    cyc(0, 0, 0, 0, 0, 1, 2'd3, 5'b00100);
    cyc(0, 1, 0, 0, 0, 1, 2'd1, 5'b10000);
    cyc(0, 1, 0, 0, 0, 0, 2'd2, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] r;
      logic       w;
      logic [1:0] a;
      r = 8'($urandom);
      w = ($urandom % 4) == 0;
      a = 2'($urandom);
      cyc(r[0], r[1], (r[7:5] == 3'd0), (r[7:5] == 3'd1), (r[7:5] == 3'd2) || (r[4:2] == 3'd7),
          w, a, 5'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule